// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block fronts the 128-byte configuration store of a network interface. Software writes a command word that names an operation and a byte address, and writes a separate 8-bit data register. The block runs the command one cycle later. It can read a cell into the data register, set or clear a write-protect latch, program one cell or every cell, erase one cell or every cell, or reload the station address. Programming ANDs the data register into the stored value, so a program can only clear bits. Erasing returns cells to all ones.

The storage is a register array. Its contents after reset come from a parameter, which lets a design or a test start from a known image. A reload checks whether cell 0 holds the signature 0xA5. If it does, cells 1 to 6 are copied into the 48-bit station address for the MAC. If it does not, the address keeps its old value and a load-failed flag is raised. Every reset triggers a reload.

Top module: `cfg_rom_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the command register becomes 0, the data register becomes 0, the protect latch is cleared, `load_fail` becomes 0, `station_addr` becomes 0, every cell takes its byte from the `INIT` parameter (cell i at bits [8i+7:8i]), and `busy` reads 1.
- R2: When `cmd_wr` is high and `busy` is low, the command register takes the value of `cmd_wdata` bits [30:28] at [30:28] and `cmd_wdata` bits [6:0] at [6:0]. All other bits are 0, except bit 4, which is ORed with the previous bit 4. `busy` then reads 1 for exactly one cycle. The command's effect is visible once `busy` has returned to 0.
- R3: A `cmd_wr` that arrives while `busy` is 1 is ignored. The command register and the storage are left unchanged.
- R4: Code 0 (read) copies the addressed cell into the data register. When the read executes, it takes priority over a `dat_wr` in the same cycle. Otherwise `dat_wr` loads `dat_wdata` into the data register.
- R5: Code 2 sets the protect latch, which enables programming. Code 1 clears it.
- R6: Code 3 (program byte) replaces the addressed cell with the cell AND the data register.
- R7: Code 4 (program all) replaces every cell with the cell AND the data register.
- R8: Code 5 (erase byte) sets the addressed cell to 0xFF.
- R9: Code 6 (erase all) sets all 128 cells to 0xFF.
- R10: While the latch is clear, codes 3, 4, 5 and 6 leave every cell unchanged.
- R11: Code 7 (reload) behaves as follows. If cell 0 is 0xA5, `station_addr` becomes {cell1, cell2, cell3, cell4, cell5, cell6}, with cell 1 in bits [47:40], and `load_fail` becomes 0. Otherwise `station_addr` is unchanged and `load_fail` becomes 1.
- R12: The first cycle after `rst` falls runs a reload. From the following cycle on, `station_addr` shows the address taken from the `INIT` image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word: operation [30:28], address [6:0] |
| dat_wr | input | 1 | Write strobe for the data register |
| dat_wdata | input | 8 | Data byte to store |
| cmd_rdata | output | 32 | Current command register |
| dat_rdata | output | 8 | Current data register |
| busy | output | 1 | High during the cycle in which a command is pending |
| load_fail | output | 1 | Last reload found no valid signature |
| station_addr | output | 48 | Station address exported to the MAC |

## Verification
The assertions check several things on every cycle: that `busy` never lasts more than one cycle, that a command written during `busy` leaves the command register alone, and that each latch, read, program-byte, erase-byte and protected operation has the right effect on the addressed cell one cycle later. They also check both outcomes of a reload. Bulk operations touch cells other than the addressed one, so only the bench's read sweeps over all 128 cells can show them. The same holds for the sticky bit 4 of the command word, the priority of a read over a data write in the same cycle, and the address reload that follows each reset.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WDIS   = 3'd1,
    OP_WEN    = 3'd2,
    OP_WRBYTE = 3'd3,
    OP_WRALL  = 3'd4,
    OP_ERBYTE = 3'd5,
    OP_ERALL  = 3'd6,
    OP_RELOAD = 3'd7
  } rom_op_e;

  localparam int OP_MSB        = 30;
  localparam int OP_LSB        = 28;
  localparam int KEEP_BIT      = 4;
  localparam int CMD_W         = 32;
  localparam int STATION_BYTES = 6;
  localparam logic [7:0] SIG_VALUE = 8'hA5;

endpackage

// File: rtl/rom_cmd_front.sv
module rom_cmd_front
  import cfg_rom_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_wr,
  input  logic [CMD_W-1:0]      cmd_wdata,
  input  logic                  dat_wr,
  input  logic [DATA_W-1:0]     dat_wdata,
  input  logic [DATA_W-1:0]     rd_byte,
  output logic [CMD_W-1:0]      cmd_q,
  output logic [DATA_W-1:0]     dat_q,
  output rom_op_e               op_q,
  output logic [ADDR_W-1:0]     addr_q,
  output logic                  go_q,
  output logic                  wen_q
);

  logic [CMD_W-1:0] cmd_next;
  logic             accept;
  logic             unused_bits;

  assign accept      = cmd_wr && !go_q;
  assign unused_bits = ^{cmd_wdata[CMD_W-1], cmd_wdata[OP_LSB-1:ADDR_W]};

  always_comb begin
    cmd_next                   = '0;
    cmd_next[OP_MSB:OP_LSB]    = cmd_wdata[OP_MSB:OP_LSB];
    cmd_next[ADDR_W-1:0]       = cmd_wdata[ADDR_W-1:0];
    cmd_next[KEEP_BIT]         = cmd_wdata[KEEP_BIT] | cmd_q[KEEP_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      dat_q  <= '0;
      op_q   <= OP_RELOAD;
      addr_q <= '0;
      go_q   <= 1'b1;
      wen_q  <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (accept) begin
        cmd_q  <= cmd_next;
        op_q   <= rom_op_e'(cmd_wdata[OP_MSB:OP_LSB]);
        addr_q <= cmd_wdata[ADDR_W-1:0];
        go_q   <= 1'b1;
      end
      if (go_q) begin
        case (op_q)
          OP_WEN:  wen_q <= 1'b1;
          OP_WDIS: wen_q <= 1'b0;
          default: wen_q <= wen_q;
        endcase
      end
      if (go_q && op_q == OP_READ) dat_q <= rd_byte;
      else if (dat_wr)             dat_q <= dat_wdata;
    end
  end

  p_busy_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    go_q |=> !go_q);
  p_cmd_store_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !go_q) |=> (go_q && cmd_q[OP_MSB:OP_LSB] == $past(cmd_wdata[OP_MSB:OP_LSB])));
  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && go_q) |=> $stable(cmd_q));
  p_latch_set_r5: assert property (@(posedge clk) disable iff (rst)
    (go_q && op_q == OP_WEN) |=> wen_q);
  p_latch_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (go_q && op_q == OP_WDIS) |=> !wen_q);
  p_read_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (go_q && op_q == OP_READ) |=> dat_q == $past(rd_byte));

endmodule

// File: rtl/rom_cell_array.sv
module rom_cell_array
  import cfg_rom_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  parameter logic [DATA_W*DEPTH-1:0] INIT = '1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            go,
  input  rom_op_e                         op,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            wen,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [DATA_W-1:0]               rd_byte,
  output logic [DATA_W-1:0]               sig_byte,
  output logic [STATION_BYTES*DATA_W-1:0] station
);

  logic [DATA_W-1:0] cells [DEPTH];

  assign rd_byte  = cells[addr];
  assign sig_byte = cells[0];

  for (genvar k = 0; k < STATION_BYTES; k++) begin : g_station
    assign station[(STATION_BYTES-1-k)*DATA_W +: DATA_W] = cells[k+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= INIT[i*DATA_W +: DATA_W];
    end else if (go && wen) begin
      case (op)
        OP_WRBYTE: cells[addr] <= cells[addr] & wr_data;
        OP_ERBYTE: cells[addr] <= '1;
        OP_WRALL:  for (int i = 0; i < DEPTH; i++) cells[i] <= cells[i] & wr_data;
        OP_ERALL:  for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        default:   ;
      endcase
    end
  end

  p_program_and_r6: assert property (@(posedge clk) disable iff (rst)
    (go && wen && op == OP_WRBYTE) |=> rd_byte == ($past(rd_byte) & $past(wr_data)));
  p_erase_cell_r8: assert property (@(posedge clk) disable iff (rst)
    (go && wen && op == OP_ERBYTE) |=> rd_byte == '1);
  p_guarded_r10: assert property (@(posedge clk) disable iff (rst)
    (go && !wen && (op == OP_WRBYTE || op == OP_WRALL || op == OP_ERBYTE || op == OP_ERALL))
      |=> $stable(rd_byte));

endmodule

// File: rtl/rom_addr_loader.sv
module rom_addr_loader
  import cfg_rom_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ST_W = STATION_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  rom_op_e           op,
  input  logic [DATA_W-1:0] sig_byte,
  input  logic [ST_W-1:0]   station,
  output logic [ST_W-1:0]   mac_q,
  output logic              fail_q
);

  logic sig_ok;
  assign sig_ok = (sig_byte == DATA_W'(SIG_VALUE));

  always_ff @(posedge clk) begin
    if (rst) begin
      mac_q  <= '0;
      fail_q <= 1'b0;
    end else if (go && op == OP_RELOAD) begin
      if (sig_ok) begin
        mac_q  <= station;
        fail_q <= 1'b0;
      end else begin
        fail_q <= 1'b1;
      end
    end
  end

  p_reload_good_r11: assert property (@(posedge clk) disable iff (rst)
    (go && op == OP_RELOAD && sig_byte == DATA_W'(SIG_VALUE))
      |=> (!fail_q && mac_q == $past(station)));
  p_reload_bad_r11: assert property (@(posedge clk) disable iff (rst)
    (go && op == OP_RELOAD && sig_byte != DATA_W'(SIG_VALUE))
      |=> (fail_q && $stable(mac_q)));

endmodule

// File: rtl/cfg_rom_ctrl.sv
module cfg_rom_ctrl
  import cfg_rom_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int ST_W  = STATION_BYTES * DATA_W,
  parameter logic [DATA_W*DEPTH-1:0] INIT =
    {{(DEPTH-7){8'hFF}}, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02, 8'hA5}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_wdata,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic [31:0]       cmd_rdata,
  output logic [DATA_W-1:0] dat_rdata,
  output logic              busy,
  output logic              load_fail,
  output logic [ST_W-1:0]   station_addr
);

  rom_op_e           op;
  logic [ADDR_W-1:0] addr;
  logic              go;
  logic              wen;
  logic [DATA_W-1:0] rd_byte;
  logic [DATA_W-1:0] sig_byte;
  logic [ST_W-1:0]   station;

  rom_cmd_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) front_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .rd_byte(rd_byte),
    .cmd_q(cmd_rdata), .dat_q(dat_rdata), .op_q(op), .addr_q(addr),
    .go_q(go), .wen_q(wen)
  );

  rom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT(INIT)) array_i (
    .clk(clk), .rst(rst), .go(go), .op(op), .addr(addr), .wen(wen),
    .wr_data(dat_rdata), .rd_byte(rd_byte), .sig_byte(sig_byte),
    .station(station)
  );

  rom_addr_loader #(.DATA_W(DATA_W)) loader_i (
    .clk(clk), .rst(rst), .go(go), .op(op), .sig_byte(sig_byte),
    .station(station), .mac_q(station_addr), .fail_q(load_fail)
  );

  assign busy = go;

endmodule

// File: tb/cfg_rom_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_rom_ctrl_tb_top;

  localparam logic [1023:0] IMG =
    {{121{8'hFF}}, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02, 8'hA5};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        dat_wr = 1'b0;
  logic [7:0]  dat_wdata = '0;
  logic [31:0] cmd_rdata;
  logic [7:0]  dat_rdata;
  logic        busy;
  logic        load_fail;
  logic [47:0] station_addr;

  int n_checks = 0;
  int n_errs   = 0;

  logic [7:0]  m [128];
  logic [7:0]  mdat;
  logic        mwen;
  logic        mb4;
  logic [47:0] mmac;
  logic        mfail;

  always #2.5 clk = ~clk;

  cfg_rom_ctrl #(.INIT(IMG)) dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .cmd_rdata(cmd_rdata),
    .dat_rdata(dat_rdata), .busy(busy), .load_fail(load_fail),
    .station_addr(station_addr)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [47:0] model_mac();
    return {m[1], m[2], m[3], m[4], m[5], m[6]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 128; i++) m[i] = IMG[i*8 +: 8];
    mdat = 8'h00; mwen = 1'b0; mb4 = 1'b0; mmac = 48'h0; mfail = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [6:0] a, input string rq);
    logic [31:0] exp;
    exp = {1'b0, op, 21'h0, a};
    exp[4] = exp[4] | mb4;
    cmd_wr = 1'b1;
    cmd_wdata = {1'b1, op, 21'h15A5A5, a};
    @(negedge clk);
    cmd_wr = 1'b0;
    chk({rq, " busy set"}, 64'(busy), 64'(1'b1));
    chk({rq, " R2 cmd word"}, 64'(cmd_rdata), 64'(exp));
    mb4 = exp[4];
    @(negedge clk);
    chk({rq, " R2 busy clear"}, 64'(busy), 64'(1'b0));
    case (op)
      3'd0: mdat = m[a];
      3'd1: mwen = 1'b0;
      3'd2: mwen = 1'b1;
      3'd3: if (mwen) m[a] = m[a] & mdat;
      3'd4: if (mwen) for (int i = 0; i < 128; i++) m[i] = m[i] & mdat;
      3'd5: if (mwen) m[a] = 8'hFF;
      3'd6: if (mwen) for (int i = 0; i < 128; i++) m[i] = 8'hFF;
      default: begin
        if (m[0] == 8'hA5) begin mmac = model_mac(); mfail = 1'b0; end
        else mfail = 1'b1;
      end
    endcase
  endtask

  task automatic dwrite(input logic [7:0] v);
    dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk);
    dat_wr = 1'b0;
    mdat = v;
  endtask

  task automatic sweep(input string rq);
    for (int a = 0; a < 128; a++) begin
      issue(3'd0, 7'(a), rq);
      chk({rq, " cell"}, 64'(dat_rdata), 64'(m[a]));
    end
  endtask

  task automatic chk_station(input string rq);
    chk({rq, " station"}, 64'(station_addr), 64'(mmac));
    chk({rq, " load_fail"}, 64'(load_fail), 64'(mfail));
  endtask

  task automatic do_reset(input string rq);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    chk({rq, " R1 busy in reset"}, 64'(busy), 64'(1'b1));
    chk({rq, " R1 cmd"}, 64'(cmd_rdata), 64'(0));
    chk({rq, " R1 dat"}, 64'(dat_rdata), 64'(0));
    chk_station({rq, " R1"});
    rst = 1'b0;
    @(negedge clk);
    mmac = model_mac(); mfail = 1'b0;
    chk({rq, " R12 busy done"}, 64'(busy), 64'(1'b0));
    chk_station({rq, " R12"});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin : main
    do_reset("first");
    sweep("R1 R4 image");

    // protected operations with the latch clear: R10
    dwrite(8'h00);
    issue(3'd3, 7'd1, "R10 prog");
    issue(3'd5, 7'd0, "R10 erase");
    issue(3'd4, 7'd0, "R10 prog all");
    issue(3'd6, 7'd0, "R10 erase all");
    sweep("R10 unchanged");

    dwrite(8'h3C);
    chk("R4 data write", 64'(dat_rdata), 64'(8'h3C));

    issue(3'd2, 7'd0, "R5 enable");

    // R3 and R4 priority: command and data write during busy
    cmd_wr = 1'b1; cmd_wdata = {1'b0, 3'd0, 21'h0, 7'd2};
    @(negedge clk);
    cmd_wdata = {1'b0, 3'd6, 21'h0, 7'd9};
    dat_wr = 1'b1; dat_wdata = 8'h5A;
    @(negedge clk);
    cmd_wr = 1'b0; dat_wr = 1'b0;
    mdat = m[2];
    chk("R4 read beats data write", 64'(dat_rdata), 64'(m[2]));
    chk("R3 cmd kept", 64'(cmd_rdata), 64'({1'b0, 3'd0, 21'h0, 7'd2} | {27'h0, mb4, 4'h0}));
    chk("R3 busy clear", 64'(busy), 64'(1'b0));
    sweep("R3 no erase");

    // R6 program byte patterns
    for (int i = 0; i < 8; i++) begin
      dwrite(~(8'h01 << i));
      issue(3'd3, 7'(8 + i), "R6 prog");
      issue(3'd0, 7'(8 + i), "R6 read");
      chk("R6 cell", 64'(dat_rdata), 64'(8'hFF & ~(8'h01 << i)));
    end
    dwrite(8'hF0);
    issue(3'd3, 7'd3, "R6 prog");
    issue(3'd0, 7'd3, "R6 read");
    chk("R6 and result", 64'(dat_rdata), 64'(8'h20));

    // R8 erase byte
    for (int i = 8; i < 12; i++) begin
      issue(3'd5, 7'(i), "R8 erase");
      issue(3'd0, 7'(i), "R8 read");
      chk("R8 cell", 64'(dat_rdata), 64'(8'hFF));
    end

    issue(3'd7, 7'd0, "R11 reload good");
    chk_station("R11 good");
    chk("R11 station value", 64'(station_addr), 64'(48'h0211_2033_4455));

    // R7 program all, breaking the signature
    dwrite(8'h7F);
    issue(3'd4, 7'd0, "R7 prog all");
    sweep("R7 all cells");
    issue(3'd7, 7'd0, "R11 reload bad");
    chk_station("R11 bad");

    // R9 erase all
    issue(3'd6, 7'd0, "R9 erase all");
    sweep("R9 all cells");

    // R5 disable then R10
    issue(3'd1, 7'd0, "R5 disable");
    dwrite(8'h00);
    issue(3'd3, 7'd0, "R10 prog");
    issue(3'd0, 7'd0, "R10 read");
    chk("R10 cell kept", 64'(dat_rdata), 64'(8'hFF));
    issue(3'd7, 7'd0, "R11 reload erased");
    chk_station("R11 erased");

    issue(3'd2, 7'd0, "R5 enable");
    dwrite(8'hA5);
    issue(3'd3, 7'd0, "R6 signature");
    issue(3'd7, 7'd0, "R11 reload ones");
    chk_station("R11 ones");

    do_reset("second");
    issue(3'd5, 7'd1, "R1 latch cleared");
    issue(3'd0, 7'd1, "R1 read");
    chk("R1 cell restored", 64'(dat_rdata), 64'(8'h02));

    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule